// File: doc/BRIEF.md
# Oblivious-Memory Bucket Slot Selector

This block keeps the metadata of one bucket in a tree-organised oblivious memory and decides which slot of that bucket a selective path read touches. The bucket has `Z` slots that carry real blocks and `S - Y` slots reserved as dummies. When the wanted block lives in the bucket, its slot is read. Otherwise one still-unread slot is drawn at random, so that an observer sees one read per bucket whether or not the bucket held anything useful.

To save storage, the block may also lend up to `Y` untouched real slots as stand-in dummies. A separate green counter tracks how many have been lent. The bucket can therefore serve `S` reads between reshuffles while reserving only `S - Y` dummy slots. After `S` reads the bucket raises a reshuffle flag. An eviction or early reshuffle then reloads the real/dummy layout and re-arms every slot.

A request is answered one clock later. The answer carries the chosen slot, whether that slot is the wanted block, or an error pulse when the request cannot be served.

Top module: `oram_bucket_selector`

## Requirements
- R1: A request with `rd_hit`=1 whose `rd_tgt` names a valid slot whose real bit is 1 is answered on the next cycle with `rsp_vld`=1, `rsp_err`=0, `rsp_tgt`=1 and `rsp_slot`=`rd_tgt`.
- R2: A request with `rd_hit`=0 starts its search at `rd_rnd` modulo the slot count `N`=`Z+S-Y`. It takes the first eligible slot found scanning upward and wrapping past `N-1` to 0. A slot is eligible when it is valid and either its real bit is 0 or the green count is below `Y`. The answer has `rsp_tgt`=0.
- R3: A selected slot becomes invalid and is never selected again before the next refill. A hit request whose target is invalid, not real, or at index `N` or above is answered with `rsp_err`=1 and changes no state.
- R4: Every served request raises the bucket access count by exactly one. The count is seen at the ports through `need_shuffle`, which rises after exactly `S` served requests.
- R5: A real slot handed out for a miss raises the green count by one. Once the green count equals `Y`, misses skip real slots.
- R6: `need_shuffle` is 1 exactly while the access count has reached `S`. Any request made while it is 1 is answered with `rsp_err`=1 and changes no state.
- R7: `refill` sets every slot valid, loads the real bits from `refill_real` (bit i for slot i, exactly `Z` ones), and zeroes both counters. A request in the same cycle is dropped with no answer.
- R8: When no slot is eligible for a miss, the answer is `rsp_err`=1. This cannot happen before `S` requests have been served since the last refill.
- R9: After reset, every slot is valid, slots 0 to `Z-1` are real, both counters are zero, and `rsp_vld` and `need_shuffle` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Slot selection request for one path read |
| rd_hit | input | 1 | Wanted block resides in this bucket |
| rd_tgt | input | IW | Slot holding the wanted block (used when `rd_hit`=1) |
| rd_rnd | input | RW | Random word for the dummy draw |
| refill | input | 1 | Eviction or reshuffle rewrote the bucket |
| refill_real | input | N | New real-bit layout, one bit per slot |
| rsp_vld | output | 1 | Answer present (one cycle after an accepted request) |
| rsp_slot | output | IW | Slot chosen for the read |
| rsp_tgt | output | 1 | Chosen slot holds the wanted block |
| rsp_err | output | 1 | Request could not be served |
| need_shuffle | output | 1 | Bucket reached `S` reads and must be reshuffled |

## Verification
The bench builds the selector with `Z`=6, `S`=10 and `Y`=3, which gives 13 slots. With 13 slots, the random draw goes through the true modulo fold rather than a bit slice. With `Y` smaller than `Z`, the green limit is reached while real slots are still valid, so the skip over real slots shows in the chosen indices. A bucket can be driven through all ten reads, past the reshuffle flag, and into refused requests within a few dozen cycles. This lets many random real/dummy layouts be exercised alongside the directed collision and invalid-target cases.

// File: rtl/oram_bkt_pkg.sv
package oram_bkt_pkg;

   // Index width that stays at least one bit for tiny ranges.
   function automatic int unsigned bkt_idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Power-of-two test used to pick the random fold variant.
   function automatic bit bkt_is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/bkt_rand_fold.sv
module bkt_rand_fold
   import oram_bkt_pkg::*;
#(
   parameter int RW = 16,
   parameter int N  = 12,
   parameter int IW = 4
) (
   input  logic [RW-1:0] rnd,
   output logic [IW-1:0] start
);

   if (RW < IW) begin : g_bad_rw
      $error("bkt_rand_fold: random word narrower than slot index");
   end

   if (bkt_is_pow2(N)) begin : g_slice
      // Slot count is a power of two: the low bits are already uniform.
      assign start = rnd[IW-1:0];
   end else begin : g_mod
      logic [RW-1:0] rem;
      assign rem   = rnd % RW'(N);
      assign start = rem[IW-1:0];
   end

endmodule

// File: rtl/bkt_slot_pick.sv
module bkt_slot_pick #(
   parameter int N  = 12,
   parameter int IW = 4
) (
   input  logic [N-1:0]  elig,
   input  logic [IW-1:0] start,
   output logic          found,
   output logic [IW-1:0] pick
);

   logic [IW:0] cand;

   // Scan from the farthest offset down to zero, so the last hit kept
   // is the nearest eligible slot at or after the start index.
   always_comb begin
      found = 1'b0;
      pick  = '0;
      cand  = '0;
      for (int k = N - 1; k >= 0; k--) begin
         cand = {1'b0, start} + (IW+1)'(k);
         if (cand >= (IW+1)'(N)) cand = cand - (IW+1)'(N);
         if (elig[cand[IW-1:0]]) begin
            found = 1'b1;
            pick  = cand[IW-1:0];
         end
      end
   end

endmodule

// File: rtl/bkt_meta_store.sv
module bkt_meta_store #(
   parameter int N  = 12,
   parameter int Z  = 8,
   parameter int S  = 12,
   parameter int Y  = 8,
   parameter int IW = 4,
   parameter int CW = 4,
   parameter int GW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          refill,
   input  logic [N-1:0]  refill_real,
   input  logic          take_en,
   input  logic [IW-1:0] take_idx,
   input  logic          take_green,
   output logic [N-1:0]  valid_q,
   output logic [N-1:0]  real_q,
   output logic [CW-1:0] acc_q,
   output logic [GW-1:0] green_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '1;
         for (int i = 0; i < N; i++) real_q[i] <= (i < Z);
         acc_q   <= '0;
         green_q <= '0;
      end else if (refill) begin
         valid_q <= '1;
         real_q  <= refill_real;
         acc_q   <= '0;
         green_q <= '0;
      end else if (take_en) begin
         valid_q[take_idx] <= 1'b0;
         acc_q             <= acc_q + CW'(1);
         if (take_green) green_q <= green_q + GW'(1);
      end
   end

   // R3: the consumed slot must still be armed.
   a_r3_take_valid: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |-> valid_q[take_idx]);

   // R4: one served request adds exactly one access.
   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (take_en && !refill) |=> (acc_q == $past(acc_q) + CW'(1)));

   // R5: green lending never passes its cap.
   a_r5_green_cap: assert property (@(posedge clk) disable iff (!rst_n)
      green_q <= GW'(Y));

   // R6: the access count never runs past the reshuffle point.
   a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q <= CW'(S));

   // R7: a refill rearms every slot and zeroes both counters.
   a_r7_refill_clear: assert property (@(posedge clk) disable iff (!rst_n)
      refill |=> (acc_q == '0 && green_q == '0 && (&valid_q)));

endmodule

// File: rtl/oram_bucket_selector.sv
module oram_bucket_selector
   import oram_bkt_pkg::*;
#(
   parameter  int Z  = 8,
   parameter  int S  = 12,
   parameter  int Y  = 8,
   parameter  int RW = 16,
   localparam int N  = Z + S - Y,
   localparam int IW = bkt_idx_w(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic          rd_hit,
   input  logic [IW-1:0] rd_tgt,
   input  logic [RW-1:0] rd_rnd,
   input  logic          refill,
   input  logic [N-1:0]  refill_real,
   output logic          rsp_vld,
   output logic [IW-1:0] rsp_slot,
   output logic          rsp_tgt,
   output logic          rsp_err,
   output logic          need_shuffle
);

   localparam int CW = bkt_idx_w(S + 1);
   localparam int GW = bkt_idx_w(Y + 1);

   if (Z < 1)      begin : g_bad_z  $error("selector: Z must be at least 1"); end
   if (Y > Z)      begin : g_bad_yz $error("selector: Y cannot exceed Z");    end
   if (Y > S)      begin : g_bad_ys $error("selector: Y cannot exceed S");    end
   if (S < 1)      begin : g_bad_s  $error("selector: S must be at least 1"); end
   if (N < 2)      begin : g_bad_n  $error("selector: bucket needs two slots"); end
   if (RW < IW)    begin : g_bad_rw $error("selector: random word too narrow"); end

   logic [N-1:0]  valid_q, real_q, elig;
   logic [CW-1:0] acc_q;
   logic [GW-1:0] green_q;
   logic [IW-1:0] start, pick, take_idx;
   logic          found, green_open, tgt_ok;
   logic          accept, serve_hit, serve_miss, take_en, take_green, err_now;

   bkt_meta_store #(
      .N(N), .Z(Z), .S(S), .Y(Y), .IW(IW), .CW(CW), .GW(GW)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .refill     (refill),
      .refill_real(refill_real),
      .take_en    (take_en),
      .take_idx   (take_idx),
      .take_green (take_green),
      .valid_q    (valid_q),
      .real_q     (real_q),
      .acc_q      (acc_q),
      .green_q    (green_q)
   );

   bkt_rand_fold #(.RW(RW), .N(N), .IW(IW)) u_fold (
      .rnd  (rd_rnd),
      .start(start)
   );

   assign green_open   = (green_q < GW'(Y));
   assign elig         = valid_q & (~real_q | {N{green_open}});
   assign need_shuffle = (acc_q >= CW'(S));

   bkt_slot_pick #(.N(N), .IW(IW)) u_pick (
      .elig (elig),
      .start(start),
      .found(found),
      .pick (pick)
   );

   // Target check without indexing past the slot range.
   always_comb begin
      tgt_ok = 1'b0;
      for (int i = 0; i < N; i++)
         if (rd_tgt == IW'(i)) tgt_ok = valid_q[i] & real_q[i];
   end

   assign accept     = rd_req & ~refill;
   assign serve_hit  = accept & ~need_shuffle &  rd_hit & tgt_ok;
   assign serve_miss = accept & ~need_shuffle & ~rd_hit & found;
   assign take_en    = serve_hit | serve_miss;
   assign take_idx   = rd_hit ? rd_tgt : pick;
   assign take_green = serve_miss & real_q[pick];
   assign err_now    = accept & ~take_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld  <= 1'b0;
         rsp_slot <= '0;
         rsp_tgt  <= 1'b0;
         rsp_err  <= 1'b0;
      end else begin
         rsp_vld  <= accept;
         rsp_slot <= take_en ? take_idx : '0;
         rsp_tgt  <= serve_hit;
         rsp_err  <= err_now;
      end
   end

   // R1: a served hit returns the slot that was asked for.
   a_r1_hit_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_tgt) |-> (rsp_slot == $past(rd_tgt)));

   // R8: before S reads a miss always finds a slot.
   a_r8_no_early_err: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !refill && !rd_hit && !need_shuffle) |-> found);

   // R6: a request against a full bucket is refused.
   a_r6_refuse_full: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !refill && need_shuffle) |=> (rsp_vld && rsp_err));

   // R7: a request colliding with a refill gets no answer.
   a_r7_drop_on_refill: assert property (@(posedge clk) disable iff (!rst_n)
      refill |=> !rsp_vld);

endmodule

// File: tb/oram_bucket_selector_test.sv
`timescale 1ns/1ps
module oram_bucket_selector_test;

   localparam int Z  = 6;
   localparam int S  = 10;
   localparam int Y  = 3;
   localparam int RW = 16;
   localparam int N  = Z + S - Y;
   localparam int IW = (N < 2) ? 1 : $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_req = 1'b0, rd_hit = 1'b0, refill = 1'b0;
   logic [IW-1:0] rd_tgt = '0;
   logic [RW-1:0] rd_rnd = '0;
   logic [N-1:0]  refill_real = '0;
   logic          rsp_vld, rsp_tgt, rsp_err, need_shuffle;
   logic [IW-1:0] rsp_slot;

   int n_chk = 0, n_bad = 0;

   // Bench model of the bucket.
   bit m_valid [N];
   bit m_real  [N];
   int m_cnt, m_green;

   always #10 clk = ~clk;

   oram_bucket_selector #(.Z(Z), .S(S), .Y(Y), .RW(RW)) uut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_hit(rd_hit),
      .rd_tgt(rd_tgt), .rd_rnd(rd_rnd), .refill(refill),
      .refill_real(refill_real), .rsp_vld(rsp_vld), .rsp_slot(rsp_slot),
      .rsp_tgt(rsp_tgt), .rsp_err(rsp_err), .need_shuffle(need_shuffle)
   );

   task automatic chk(input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_refill(input logic [N-1:0] mask);
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 1'b1;
         m_real[i]  = mask[i];
      end
      m_cnt   = 0;
      m_green = 0;
   endtask

   function automatic logic [N-1:0] rand_mask();
      bit b [N];
      logic [N-1:0] m;
      for (int i = 0; i < N; i++) b[i] = (i < Z);
      for (int i = N - 1; i > 0; i--) begin
         int j = $urandom_range(i, 0);
         bit t = b[i];
         b[i] = b[j];
         b[j] = t;
      end
      for (int i = 0; i < N; i++) m[i] = b[i];
      return m;
   endfunction

   task automatic do_refill(input logic [N-1:0] mask);
      @(negedge clk);
      refill = 1'b1;
      refill_real = mask;
      @(posedge clk);
      #1;
      refill = 1'b0;
      model_refill(mask);
      chk("R7", "need_shuffle after refill", need_shuffle, 0);
      chk("R7", "no answer after refill", rsp_vld, 0);
   endtask

   task automatic do_req(input bit hit, input int tgt, input int rnd);
      bit e_err, e_tgt;
      int e_slot, start;
      string tag;
      e_err = 1'b0; e_tgt = 1'b0; e_slot = 0;
      if (m_cnt >= S) begin
         e_err = 1'b1;
         tag = "R6";
      end else if (hit) begin
         tag = "R1";
         if (tgt < N && m_valid[tgt] && m_real[tgt]) begin
            e_tgt = 1'b1;
            e_slot = tgt;
         end else begin
            e_err = 1'b1;
            tag = "R3";
         end
      end else begin
         tag = "R2";
         e_err = 1'b1;
         start = rnd % N;
         for (int k = 0; k < N; k++) begin
            int ix = (start + k) % N;
            if (e_err && m_valid[ix] && (!m_real[ix] || m_green < Y)) begin
               e_err = 1'b0;
               e_slot = ix;
            end
         end
         if (e_err) tag = "R8";
         else if (m_real[e_slot]) tag = "R5";
      end
      if (!e_err) begin
         m_valid[e_slot] = 1'b0;
         m_cnt++;
         if (!hit && m_real[e_slot]) m_green++;
      end
      @(negedge clk);
      rd_req = 1'b1;
      rd_hit = hit;
      rd_tgt = IW'(tgt);
      rd_rnd = RW'(rnd);
      @(posedge clk);
      #1;
      rd_req = 1'b0;
      chk(tag, "rsp_vld", rsp_vld, 1);
      chk(tag, "rsp_err", rsp_err, e_err);
      if (!e_err) begin
         chk(tag, "rsp_slot", rsp_slot, e_slot);
         chk(tag, "rsp_tgt", rsp_tgt, e_tgt);
      end
      chk("R4", "need_shuffle", need_shuffle, (m_cnt >= S));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [N-1:0] rst_mask;
      void'($urandom(32'd2024));
      for (int i = 0; i < N; i++) rst_mask[i] = (i < Z);
      model_refill(rst_mask);
      repeat (3) @(posedge clk);
      #1;
      chk("R9", "rsp_vld at reset", rsp_vld, 0);
      chk("R9", "need_shuffle at reset", need_shuffle, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: reset layout puts real blocks in the low slots.
      do_req(1'b1, Z, 0);        // dummy slot as target: refused (R3)
      do_req(1'b1, 2, 0);        // real slot 2 served (R1)
      do_req(1'b1, 2, 0);        // already read: refused (R3)
      do_req(1'b1, N + 1, 0);    // out-of-range target: refused (R3)
      // Misses from 0: green lending up to Y, then real slots skipped (R5).
      for (int i = 0; i < S - 1; i++) do_req(1'b0, 0, 0);
      do_req(1'b0, 7, 7);        // full bucket: refused (R6)
      do_req(1'b1, 0, 0);

      // R7: refill colliding with a request drops the request.
      @(negedge clk);
      refill = 1'b1;
      refill_real = rand_mask();
      rd_req = 1'b1;
      rd_hit = 1'b0;
      @(posedge clk);
      #1;
      model_refill(refill_real);
      refill = 1'b0;
      rd_req = 1'b0;
      @(posedge clk);
      #1;
      chk("R7", "dropped request answer", rsp_vld, 0);
      chk("R7", "need_shuffle after collision", need_shuffle, 0);

      // R2: wrap of the scan past the top slot.
      do_refill(rand_mask());
      do_req(1'b0, 0, N - 1);
      do_req(1'b0, 0, 2 * N - 1);

      // Random rounds.
      for (int r = 0; r < 80; r++) begin
         do_refill(rand_mask());
         for (int q = 0; q < S + 2; q++) begin
            int pk = $urandom_range(2, 0);
            if (pk == 0) do_req(1'b1, $urandom_range((1 << IW) - 1, 0), 0);
            else         do_req(1'b0, 0, $urandom_range(65535, 0));
         end
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule